// File: doc/BRIEF.md
# Rename Admission Credit Limiter

This block sits at the rename stage of an out-of-order core and decides, once per cycle, how many instructions at the head of the rename queue may leave for dispatch. Downstream queues report their free space as credit snapshots: reorder buffer, issue queue, load queue and store queue. Those reports trail behind what rename has already sent. The block therefore keeps its own counts of instructions, loads and stores that it has sent but that dispatch has not yet acknowledged. It subtracts the unacknowledged part from each snapshot to get the space that is really left.

Each cycle the block is given the number of queued instructions it may look at, together with a small window of per-instruction flags: load, store-or-atomic, squashed, and the number of destination registers needed. It also gets the number of free physical registers. It walks the window in order. It stops at the rename width, at the first memory operation whose queue has no room, or at the first instruction that cannot get its destination registers. It then reports how many entries leave the queue, how many of those are real sends, whether the stage must block, and the reason for any shortfall. All results are registered: they appear one clock after the inputs that produced them.

Top module: `rn_admit_limiter`

## Requirements
- R1: Synchronous active-high reset clears all outputs to zero and clears the three in-flight counts. The first cycle after reset sees free space equal to the raw credit snapshots.
- R2: Free ROB space is the ROB credit minus (instructions in flight minus instructions acknowledged this cycle). Free IQ space uses the same formula with the IQ credit. All of this is signed arithmetic, so the result may be negative.
- R3: The admission limit is the smaller of free ROB and free IQ. The associated cause code is 1 (ROB) when ROB is smaller or the two are equal, and 2 (IQ) otherwise.
- R4: With at least one instruction available and a limit of zero or less, nothing is taken, block is asserted, and the cause is the limit's code.
- R5: With a positive limit below the available count, the available count is cut to the limit, block is asserted, and the cause is the limit's code.
- R6: No more than WIDTH instructions are sent in one cycle. Once WIDTH have been sent, no later entry is removed, squashed or not.
- R7: A load is refused when free LQ space, less the loads already accepted this cycle, is zero or less. The scan stops there with cause 3 (LQ). A refusal does not by itself assert block.
- R8: An instruction flagged store-or-atomic is refused when free SQ space, less the stores already accepted this cycle, is zero or less. The scan stops there with cause 4 (SQ).
- R9: A squashed entry is removed: it counts in the take output and against the available total. It is not sent, uses no rename-width slot, and needs no queue space or registers.
- R10: When an instruction needs more destination registers than remain free after earlier accepts this cycle, it stays at the head, the scan stops, block is asserted, and the cause is 5 (registers).
- R11: The in-flight instruction, load and store counts grow by the instructions, loads and stores sent each cycle. They shrink by the matching acknowledgements. Free LQ is credit minus (loads in flight minus load acknowledgements), and free SQ is computed the same way from the store counts.
- R12: With zero instructions available, take and send are zero, block is low and the cause is 0, whatever the credits are.
- R13: Take, send, block and cause are registered. They reflect the inputs and in-flight counts of the previous clock cycle. A later shortfall cause replaces an earlier limit cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_rob_credit | input | CRED_W | Last reported free ROB entries |
| i_iq_credit | input | CRED_W | Last reported free IQ entries |
| i_lq_credit | input | CRED_W | Last reported free LQ entries |
| i_sq_credit | input | CRED_W | Last reported free SQ entries |
| i_inst_ack | input | CRED_W | Instructions acknowledged as dispatched |
| i_load_ack | input | CRED_W | Loads acknowledged into the LQ |
| i_store_ack | input | CRED_W | Stores acknowledged into the SQ |
| i_avail | input | clog2(AV+1) | Number of queued instructions available |
| i_is_load | input | AV | Per-slot load flag, slot 0 is the queue head |
| i_is_store | input | AV | Per-slot store-or-atomic flag |
| i_squashed | input | AV | Per-slot squashed flag |
| i_dst_cnt | input | AV*DST_W | Per-slot destination register count |
| i_free_regs | input | REG_W | Free physical registers |
| o_take | output | clog2(AV+1) | Entries removed from the queue head |
| o_send | output | clog2(WIDTH+1) | Instructions sent to dispatch |
| o_block | output | 1 | Block this cycle |
| o_cause | output | 3 | Shortfall cause: 0 none, 1 ROB, 2 IQ, 3 LQ, 4 SQ, 5 registers |

## Verification
The bench builds the block with WIDTH=4, AV=6, CRED_W=6, REG_W=6 and DST_W=2. A six-entry window behind a width of four makes the width cut reachable, including squashed entries that sit beyond it. Six-bit credits, together with in-flight counts that can run past them, make free space go negative and make ties between ROB and IQ common. Register counts up to twelve next to destination counts up to three make the register stop happen often in the random phase.

// File: rtl/rn_admit_pkg.sv
package rn_admit_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_ROB  = 3'd1,
    CAUSE_IQ   = 3'd2,
    CAUSE_LQ   = 3'd3,
    CAUSE_SQ   = 3'd4,
    CAUSE_REG  = 3'd5
  } full_cause_e;

  localparam int RES_N   = 4;
  localparam int RES_ROB = 0;
  localparam int RES_IQ  = 1;
  localparam int RES_LQ  = 2;
  localparam int RES_SQ  = 3;

  localparam int CTR_N     = 3;
  localparam int CTR_INST  = 0;
  localparam int CTR_LOAD  = 1;
  localparam int CTR_STORE = 2;

endpackage

// File: rtl/rn_free_calc.sv
module rn_free_calc #(
  parameter int CRED_W = 7,
  parameter int CW     = 11
) (
  input  logic [CRED_W-1:0]    i_credit,
  input  logic signed [CW-1:0] i_inflight,
  input  logic [CRED_W-1:0]    i_ack,
  output logic signed [CW-1:0] o_free
);

  logic signed [CW-1:0] credit_s;
  logic signed [CW-1:0] ack_s;
  logic signed [CW-1:0] pending;

  assign credit_s = $signed(CW'(i_credit));
  assign ack_s    = $signed(CW'(i_ack));
  assign pending  = i_inflight - ack_s;
  assign o_free   = credit_s - pending;

endmodule

// File: rtl/rn_inflight_ctr.sv
module rn_inflight_ctr #(
  parameter int CW    = 11,
  parameter int INC_W = 3,
  parameter int DEC_W = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [INC_W-1:0]     i_inc,
  input  logic [DEC_W-1:0]     i_dec,
  output logic signed [CW-1:0] o_count
);

  always_ff @(posedge clk) begin
    if (rst) begin
      o_count <= '0;
    end else begin
      o_count <= o_count + $signed(CW'(i_inc)) - $signed(CW'(i_dec));
    end
  end

  // R11: no sends and no acknowledgements leave the count alone
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (i_inc == '0 && i_dec == '0) |=> $stable(o_count));

endmodule

// File: rtl/rn_admit_scan.sv
module rn_admit_scan
  import rn_admit_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter int AV     = 8,
  parameter int DST_W  = 2,
  parameter int REG_W  = 7,
  parameter int CW     = 11,
  parameter int AVC_W  = 4,
  parameter int SEND_W = 3
) (
  input  logic [AVC_W-1:0]     i_avail,
  input  logic signed [CW-1:0] i_free_lq,
  input  logic signed [CW-1:0] i_free_sq,
  input  logic [REG_W-1:0]     i_free_regs,
  input  logic [AV-1:0]        i_is_load,
  input  logic [AV-1:0]        i_is_store,
  input  logic [AV-1:0]        i_squashed,
  input  logic [AV*DST_W-1:0]  i_dst_cnt,
  output logic [AVC_W-1:0]     o_take,
  output logic [SEND_W-1:0]    o_send,
  output logic [SEND_W-1:0]    o_loads,
  output logic [SEND_W-1:0]    o_stores,
  output logic                 o_reg_stop,
  output full_cause_e          o_cause
);

  always_comb begin
    int take;
    int sent;
    int nld;
    int nst;
    int used;
    int fl;
    int fs;
    int fr;
    int dc;
    logic halt;
    take = 0;
    sent = 0;
    nld  = 0;
    nst  = 0;
    used = 0;
    halt = 1'b0;
    fl   = int'(i_free_lq);
    fs   = int'(i_free_sq);
    fr   = int'(i_free_regs);
    o_reg_stop = 1'b0;
    o_cause    = CAUSE_NONE;
    for (int i = 0; i < AV; i++) begin
      dc = int'(i_dst_cnt[i*DST_W +: DST_W]);
      if (!halt && i < int'(i_avail) && sent < WIDTH) begin
        if (i_squashed[i]) begin
          take = take + 1;
        end else if (i_is_load[i] && (fl - nld) <= 0) begin
          halt    = 1'b1;
          o_cause = CAUSE_LQ;
        end else if (i_is_store[i] && (fs - nst) <= 0) begin
          halt    = 1'b1;
          o_cause = CAUSE_SQ;
        end else if (dc > (fr - used)) begin
          halt       = 1'b1;
          o_reg_stop = 1'b1;
          o_cause    = CAUSE_REG;
        end else begin
          take = take + 1;
          sent = sent + 1;
          used = used + dc;
          if (i_is_load[i])  nld = nld + 1;
          if (i_is_store[i]) nst = nst + 1;
        end
      end else begin
        halt = 1'b1;
      end
    end
    o_take   = AVC_W'(take);
    o_send   = SEND_W'(sent);
    o_loads  = SEND_W'(nld);
    o_stores = SEND_W'(nst);
  end

endmodule

// File: rtl/rn_admit_limiter.sv
module rn_admit_limiter
  import rn_admit_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter int AV     = 8,
  parameter int CRED_W = 7,
  parameter int REG_W  = 7,
  parameter int DST_W  = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [CRED_W-1:0]           i_rob_credit,
  input  logic [CRED_W-1:0]           i_iq_credit,
  input  logic [CRED_W-1:0]           i_lq_credit,
  input  logic [CRED_W-1:0]           i_sq_credit,
  input  logic [CRED_W-1:0]           i_inst_ack,
  input  logic [CRED_W-1:0]           i_load_ack,
  input  logic [CRED_W-1:0]           i_store_ack,
  input  logic [$clog2(AV+1)-1:0]     i_avail,
  input  logic [AV-1:0]               i_is_load,
  input  logic [AV-1:0]               i_is_store,
  input  logic [AV-1:0]               i_squashed,
  input  logic [AV*DST_W-1:0]         i_dst_cnt,
  input  logic [REG_W-1:0]            i_free_regs,
  output logic [$clog2(AV+1)-1:0]     o_take,
  output logic [$clog2(WIDTH+1)-1:0]  o_send,
  output logic                        o_block,
  output logic [2:0]                  o_cause
);

  localparam int CW     = CRED_W + 4;
  localparam int AVC_W  = $clog2(AV + 1);
  localparam int SEND_W = $clog2(WIDTH + 1);

  // in-flight counters
  logic signed [CW-1:0] cnt_v [CTR_N];
  logic [SEND_W-1:0]    inc_v [CTR_N];
  logic [CRED_W-1:0]    dec_v [CTR_N];
  logic [SEND_W-1:0]    scan_send;
  logic [SEND_W-1:0]    scan_loads;
  logic [SEND_W-1:0]    scan_stores;

  assign inc_v[CTR_INST]  = scan_send;
  assign inc_v[CTR_LOAD]  = scan_loads;
  assign inc_v[CTR_STORE] = scan_stores;
  assign dec_v[CTR_INST]  = i_inst_ack;
  assign dec_v[CTR_LOAD]  = i_load_ack;
  assign dec_v[CTR_STORE] = i_store_ack;

  for (genvar c = 0; c < CTR_N; c++) begin : g_ctr
    rn_inflight_ctr #(
      .CW    (CW),
      .INC_W (SEND_W),
      .DEC_W (CRED_W)
    ) u_ctr (
      .clk     (clk),
      .rst     (rst),
      .i_inc   (inc_v[c]),
      .i_dec   (dec_v[c]),
      .o_count (cnt_v[c])
    );
  end

  // free-space estimates
  logic [CRED_W-1:0]    cred_v [RES_N];
  logic signed [CW-1:0] free_v [RES_N];

  assign cred_v[RES_ROB] = i_rob_credit;
  assign cred_v[RES_IQ]  = i_iq_credit;
  assign cred_v[RES_LQ]  = i_lq_credit;
  assign cred_v[RES_SQ]  = i_sq_credit;

  for (genvar r = 0; r < RES_N; r++) begin : g_free
    localparam int SRC = (r == RES_LQ) ? CTR_LOAD :
                         (r == RES_SQ) ? CTR_STORE : CTR_INST;
    rn_free_calc #(
      .CRED_W (CRED_W),
      .CW     (CW)
    ) u_free (
      .i_credit   (cred_v[r]),
      .i_inflight (cnt_v[SRC]),
      .i_ack      (dec_v[SRC]),
      .o_free     (free_v[r])
    );
  end

  // ROB / IQ limit and clipping of the available count
  logic signed [CW-1:0] lim;
  full_cause_e          lim_src;
  logic signed [CW-1:0] avail_s;
  logic [AVC_W-1:0]     avail_eff;
  logic                 lim_block;
  full_cause_e          lim_cause;

  assign avail_s = $signed(CW'(i_avail));

  always_comb begin
    if (free_v[RES_IQ] < free_v[RES_ROB]) begin
      lim     = free_v[RES_IQ];
      lim_src = CAUSE_IQ;
    end else begin
      lim     = free_v[RES_ROB];
      lim_src = CAUSE_ROB;
    end
  end

  always_comb begin
    avail_eff = i_avail;
    lim_block = 1'b0;
    lim_cause = CAUSE_NONE;
    if (i_avail == '0) begin
      avail_eff = '0;
    end else if (lim <= 0) begin
      avail_eff = '0;
      lim_block = 1'b1;
      lim_cause = lim_src;
    end else if (lim < avail_s) begin
      avail_eff = AVC_W'(lim);
      lim_block = 1'b1;
      lim_cause = lim_src;
    end
  end

  // in-order scan of the window
  logic [AVC_W-1:0] scan_take;
  logic             scan_reg_stop;
  full_cause_e      scan_cause;

  rn_admit_scan #(
    .WIDTH  (WIDTH),
    .AV     (AV),
    .DST_W  (DST_W),
    .REG_W  (REG_W),
    .CW     (CW),
    .AVC_W  (AVC_W),
    .SEND_W (SEND_W)
  ) u_scan (
    .i_avail     (avail_eff),
    .i_free_lq   (free_v[RES_LQ]),
    .i_free_sq   (free_v[RES_SQ]),
    .i_free_regs (i_free_regs),
    .i_is_load   (i_is_load),
    .i_is_store  (i_is_store),
    .i_squashed  (i_squashed),
    .i_dst_cnt   (i_dst_cnt),
    .o_take      (scan_take),
    .o_send      (scan_send),
    .o_loads     (scan_loads),
    .o_stores    (scan_stores),
    .o_reg_stop  (scan_reg_stop),
    .o_cause     (scan_cause)
  );

  // registered results
  always_ff @(posedge clk) begin
    if (rst) begin
      o_take  <= '0;
      o_send  <= '0;
      o_block <= 1'b0;
      o_cause <= CAUSE_NONE;
    end else begin
      o_take  <= scan_take;
      o_send  <= scan_send;
      o_block <= lim_block | scan_reg_stop;
      o_cause <= (scan_cause != CAUSE_NONE) ? scan_cause : lim_cause;
    end
  end

  // R4: no room in ROB/IQ with work waiting blocks with nothing taken
  p_limit_block_r4: assert property (@(posedge clk) disable iff (rst)
    (i_avail != '0 && lim <= 0) |=> (o_block && o_take == '0));

  // R12: an empty queue never blocks and reports no cause
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (i_avail == '0) |=> (o_take == '0 && !o_block && o_cause == 3'd0));

  // R6: sends never exceed the rename width
  p_width_cap_r6: assert property (@(posedge clk) disable iff (rst)
    o_send <= SEND_W'(WIDTH));

  // R9: squashed entries add to take but never to send
  p_send_in_take_r9: assert property (@(posedge clk) disable iff (rst)
    AVC_W'(o_send) <= o_take);

  // R10: a register shortage always blocks
  p_reg_blocks_r10: assert property (@(posedge clk) disable iff (rst)
    (o_cause == CAUSE_REG) |-> o_block);

endmodule

// File: tb/test_rn_admit_limiter.sv
module test_rn_admit_limiter;

  localparam int W   = 4;
  localparam int AV  = 6;
  localparam int CRW = 6;
  localparam int RGW = 6;
  localparam int DW  = 2;
  localparam int AVW = $clog2(AV + 1);
  localparam int SDW = $clog2(W + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CRW-1:0] rob, iq, lq, sq, ack_i, ack_l, ack_s;
  logic [AVW-1:0] avail;
  logic [AV-1:0]  ldf, stf, sqf;
  logic [AV*DW-1:0] dst;
  logic [RGW-1:0] fregs;
  logic [AVW-1:0] o_take;
  logic [SDW-1:0] o_send;
  logic           o_block;
  logic [2:0]     o_cause;

  always #5 clk = ~clk;

  rn_admit_limiter #(
    .WIDTH (W), .AV (AV), .CRED_W (CRW), .REG_W (RGW), .DST_W (DW)
  ) i_rn_admit_limiter (
    .clk (clk), .rst (rst),
    .i_rob_credit (rob), .i_iq_credit (iq), .i_lq_credit (lq), .i_sq_credit (sq),
    .i_inst_ack (ack_i), .i_load_ack (ack_l), .i_store_ack (ack_s),
    .i_avail (avail), .i_is_load (ldf), .i_is_store (stf), .i_squashed (sqf),
    .i_dst_cnt (dst), .i_free_regs (fregs),
    .o_take (o_take), .o_send (o_send), .o_block (o_block), .o_cause (o_cause)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int m_inst = 0, m_ld = 0, m_st = 0;
  int e_take, e_send, e_block, e_cause;
  bit finished = 1'b0;

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "take",  int'(o_take),  e_take);
    chk(tag, "send",  int'(o_send),  e_send);
    chk(tag, "block", int'(o_block), e_block);
    chk(tag, "cause", int'(o_cause), e_cause);
  endtask

  // behavioural reference for one cycle; also advances the in-flight model
  task automatic model_step();
    int frob, fiq, flq, fsq, lim, lc, av, take, sent, nl, ns, used, d;
    int blk, cause;
    frob = int'(rob) - (m_inst - int'(ack_i));
    fiq  = int'(iq)  - (m_inst - int'(ack_i));
    flq  = int'(lq)  - (m_ld   - int'(ack_l));
    fsq  = int'(sq)  - (m_st   - int'(ack_s));
    if (fiq < frob) begin lim = fiq; lc = 2; end
    else begin lim = frob; lc = 1; end
    blk = 0; cause = 0; av = int'(avail);
    if (av == 0) begin
      av = 0;
    end else if (lim <= 0) begin
      av = 0; blk = 1; cause = lc;
    end else if (lim < av) begin
      av = lim; blk = 1; cause = lc;
    end
    take = 0; sent = 0; nl = 0; ns = 0; used = 0;
    for (int k = 0; k < av; k++) begin
      if (sent >= W) break;
      if (sqf[k]) begin take++; continue; end
      if (ldf[k] && flq - nl <= 0) begin cause = 3; break; end
      if (stf[k] && fsq - ns <= 0) begin cause = 4; break; end
      d = int'(dst[k*DW +: DW]);
      if (d > int'(fregs) - used) begin blk = 1; cause = 5; break; end
      take++; sent++; used += d;
      if (ldf[k]) nl++;
      if (stf[k]) ns++;
    end
    e_take = take; e_send = sent; e_block = blk; e_cause = cause;
    m_inst = m_inst + sent - int'(ack_i);
    m_ld   = m_ld + nl - int'(ack_l);
    m_st   = m_st + ns - int'(ack_s);
  endtask

  task automatic apply(string tag);
    if (int'(ack_i) > m_inst) ack_i = CRW'(m_inst);
    if (int'(ack_l) > m_ld)   ack_l = CRW'(m_ld);
    if (int'(ack_s) > m_st)   ack_s = CRW'(m_st);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic clr();
    rob = 6'd40; iq = 6'd40; lq = 6'd40; sq = 6'd40;
    ack_i = '0; ack_l = '0; ack_s = '0;
    avail = '0; ldf = '0; stf = '0; sqf = '0; dst = '0; fregs = 6'd63;
  endtask

  task automatic ack_all();
    ack_i = CRW'(m_inst); ack_l = CRW'(m_ld); ack_s = CRW'(m_st);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R13 watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    clr();
    repeat (3) @(posedge clk);
    @(negedge clk);
    e_take = 0; e_send = 0; e_block = 0; e_cause = 0;
    compare("R1");
    rst = 1'b0;

    // R1 R3: counts start at zero; ROB/IQ tie reports ROB
    rob = 6'd2; iq = 6'd2; avail = AVW'(3);
    apply("R1 R3");
    clr(); ack_all();
    apply("R12");
    // R12: credits exhausted but nothing available
    clr(); rob = 6'd0; iq = 6'd0;
    apply("R12");
    // R2 R5: limit below available, width also in play
    clr(); rob = 6'd5; iq = 6'd9; avail = AVW'(6);
    apply("R2 R5");
    // R3: IQ smaller, acknowledgements returned
    clr(); rob = 6'd9; iq = 6'd1; avail = AVW'(3); ack_all();
    apply("R3");
    // R2: in flight without acks eats the ROB credit
    clr(); rob = 6'd2; iq = 6'd30; avail = AVW'(4);
    apply("R2");
    // R4: zero and negative free space
    clr(); rob = 6'd0; avail = AVW'(3);
    apply("R4");
    clr(); rob = 6'd1; iq = 6'd1; avail = AVW'(2);
    apply("R4");
    // R6: width cut with plenty of credit
    clr(); ack_all(); avail = AVW'(6);
    apply("R6");
    clr(); ack_all(); avail = AVW'(6); sqf = 6'b110000;
    apply("R6 R9");
    // R7: second load refused, LQ in flight then blocks first load
    clr(); ack_all(); lq = 6'd1; avail = AVW'(3); ldf = 6'b000011;
    apply("R7");
    clr(); lq = 6'd1; avail = AVW'(2); ldf = 6'b000001; ack_i = CRW'(m_inst);
    apply("R7 R11");
    // R8: store refused with no SQ space
    clr(); ack_all(); sq = 6'd0; avail = AVW'(4); stf = 6'b000100;
    apply("R8");
    clr(); ack_all(); sq = 6'd1; avail = AVW'(4); stf = 6'b000110;
    apply("R8");
    // R9: squashed entries skip resources and width
    clr(); ack_all(); avail = AVW'(6); sqf = 6'b000011;
    apply("R9");
    clr(); ack_all(); rob = 6'd3; avail = AVW'(5); sqf = 6'b000011;
    apply("R9 R5");
    clr(); ack_all(); lq = 6'd0; avail = AVW'(3); ldf = 6'b000001; sqf = 6'b000001;
    apply("R9");
    // R10: register shortage
    clr(); ack_all(); fregs = 6'd3; avail = AVW'(3); dst = 12'b00_00_00_00_10_10;
    apply("R10");
    clr(); ack_all(); fregs = 6'd0; avail = AVW'(2); dst = 12'b00_00_00_00_01_00;
    apply("R10");
    // R11: in-flight counting with partial acknowledgements
    clr(); ack_all(); avail = AVW'(4); ldf = 6'b000101; stf = 6'b000010;
    apply("R11");
    clr(); rob = 6'd6; iq = 6'd6; avail = AVW'(6);
    apply("R11");
    clr(); rob = 6'd6; iq = 6'd6; avail = AVW'(6); ack_i = CRW'(2);
    lq = 6'd2; ldf = 6'b000001; ack_l = CRW'(1);
    apply("R11");

    // R11 R13: random traffic, compared every cycle
    for (int t = 0; t < 400; t++) begin
      rob = CRW'($urandom_range(0, 20));
      iq  = CRW'($urandom_range(0, 20));
      lq  = CRW'($urandom_range(0, 6));
      sq  = CRW'($urandom_range(0, 6));
      avail = AVW'($urandom_range(0, AV));
      ldf = AV'($urandom); stf = AV'($urandom) & ~ldf;
      sqf = AV'($urandom & $urandom);
      dst = (AV*DW)'($urandom);
      fregs = RGW'($urandom_range(0, 12));
      if (m_inst > 30 || $urandom_range(0, 3) == 0) ack_all();
      else begin
        ack_i = CRW'($urandom_range(0, m_inst));
        ack_l = CRW'($urandom_range(0, m_ld));
        ack_s = CRW'($urandom_range(0, m_st));
      end
      apply("R11 R13");
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule